// File: doc/BRIEF.md
# Collision and Controller Status Read Port

This block is a small read-only status bank for a video and input controller. Six display objects each present a per-pixel enable. Whenever two of them are enabled in the same cycle, the flag for that pair of objects is latched and stays set. There are fifteen such flags, one for every unordered pair. Six controller pins are brought into the clock domain through two flip-flops each and are also made readable.

A CPU reads the bank through an address, a read strobe and a two-bit data value that stands for data-bus bits 7 and 6. A drive-enable qualifies that value. Bits 5 to 0 of the bus are never produced, so the surrounding bus leaves them floating. Two conditions share each collision address, one on bit 7 and one on bit 6. A single bit-test read therefore loads both of them into the CPU's sign and overflow flags and leaves the accumulator untouched. A write strobe clears all collision flags at once.

Top module: `coll_status_port`

## Requirements
- R1: After a synchronous active-low reset, all fifteen collision flags read 0 and all controller bits read 0.
- R2: If two objects' enables are both high in a cycle, the flag for that pair reads 1 from the next clock edge on and stays 1 until it is cleared.
- R3: Pairs (i,j) with i<j are numbered k = 0..14 in the order (0,1),(0,2)..(0,5),(1,2)..(1,5),(2,3),(2,4),(2,5),(3,4),(3,5),(4,5). Flag k is at address k/2. An even k is on bit 7 (rd_data[1]) and an odd k is on bit 6 (rd_data[0]).
- R4: A cycle with at most one object enabled sets no flag.
- R5: A cycle with clr_we high clears all fifteen flags at the next edge.
- R6: If clr_we is high in the same cycle as a collision on a pair, the flag for that pair reads 1 afterwards.
- R7: Bit 6 of address 7 has no flag and always reads 0.
- R8: Controller pin p reads on bit 7 of address 8+p, two clock edges after it changes, and bit 6 of those addresses reads 0.
- R9: rd_oe is 1 only when rd_en is high and the address is in 0..13. While rd_oe is 0, rd_data is 0.
- R10: Reading any address does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obj_en | input | 6 | Per-pixel enable of each display object |
| pad_in | input | 6 | Asynchronous controller pins |
| rd_addr | input | 4 | Read address |
| rd_en | input | 1 | Read strobe |
| clr_we | input | 1 | Clear-all-collisions write strobe |
| rd_data | output | 2 | Data bits 7 (index 1) and 6 (index 0) |
| rd_oe | output | 1 | Drive-enable for the two data bits |

## Verification
The table drives object patterns one at a time, each after a clear, and reads back all eight collision addresses. A single object must set nothing. Pairs are chosen to land on bit 7 and on bit 6, at the first, middle and last addresses, so that a swapped bit or a wrong pair numbering shows up. A pattern with three objects must set exactly its three pair flags, and a pattern with all six must set all fifteen flags while the spare bit stays 0. Directed tests then check the following:
- a clear combined with a new collision, where the new pair must survive and the other flags must be cleared;
- the one-cycle-late visibility of controller pins, which tells a two-stage synchronizer from a one-stage one;
- reads at unmapped addresses and reads with the strobe low;
- that repeated reads leave the flags intact.

// File: rtl/coll_status_pkg.sv
// Shared helpers for the collision/controller status port.
// Assumes objects are numbered from 0 and that pairs are taken with i<j.
package coll_status_pkg;

    // Linear index of the unordered pair (i,j), i<j, among n objects.
    function automatic int pair_idx(input int i, input int j, input int n);
        return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/coll_detect.sv
// Sticky pairwise collision flags.
// Each flag k is set on any cycle in which both objects of pair k are
// enabled, and it is held until the clear strobe. A new hit in the same
// cycle as the clear wins over the clear.
// Assumes obj_en is already synchronous to clk.
module coll_detect
    import coll_status_pkg::*;
#(
    parameter int NUM_OBJ  = 6,
    localparam int NUM_PAIR = NUM_OBJ * (NUM_OBJ - 1) / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_OBJ-1:0]  obj_en,
    input  logic                clr,
    output logic [NUM_PAIR-1:0] flags
);
    logic [NUM_PAIR-1:0] hit;

    // One AND gate for each unordered pair of objects.
    for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < NUM_OBJ; gj++) begin : g_col
            assign hit[pair_idx(gi, gj, NUM_OBJ)] = obj_en[gi] & obj_en[gj];
        end
    end

    // Hold the flags, clear them on the strobe, and set them on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & {NUM_PAIR{~clr}}) | hit;
    end
endmodule

// File: rtl/pad_sync.sv
// Two-flip-flop synchronizer for the controller pins.
// Assumes each pin is a slow level signal, so single-bit synchronization
// is enough and there is no relation between the bits.
module pad_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta;

    // Two register stages between the pin and the readable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            dout <= '0;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/status_read_mux.sv
// Combinational read decode for the status bank.
// Collision addresses 0..NCA-1 carry two flags each, on bits 7 and 6.
// Controller addresses PAD_BASE.. carry one pin each, on bit 7.
// Any other address, or a read with the strobe low, produces no drive.
module status_read_mux #(
    parameter int NUM_PAIR = 15,
    parameter int NUM_PAD  = 6,
    parameter int ADDR_W   = 4,
    parameter int PAD_BASE = 8,
    localparam int NCA     = (NUM_PAIR + 1) / 2
) (
    input  logic [NUM_PAIR-1:0] flags,
    input  logic [NUM_PAD-1:0]  pads,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_en,
    output logic [1:0]          rd_data,
    output logic                rd_oe
);
    logic [2*NCA-1:0] flags_ext;

    // Pad the flag vector to an even width so that the spare slot reads 0.
    assign flags_ext = (2 * NCA)'(flags);

    // Decode the address and route the selected bits to the port.
    always_comb begin
        rd_data = 2'b00;
        rd_oe   = 1'b0;
        if (rd_en) begin
            for (int a = 0; a < NCA; a++) begin
                if (rd_addr == ADDR_W'(a)) begin
                    rd_oe   = 1'b1;
                    rd_data = {flags_ext[2*a], flags_ext[2*a+1]};
                end
            end
            for (int p = 0; p < NUM_PAD; p++) begin
                if (rd_addr == ADDR_W'(PAD_BASE + p)) begin
                    rd_oe   = 1'b1;
                    rd_data = {pads[p], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/coll_status_port.sv
// Top level of the collision/controller status port.
// Only data bits 7 and 6 exist here. The bus outside leaves bits 5..0
// undriven. Assumes obj_en is synchronous to clk and pad_in is not.
module coll_status_port #(
    parameter int NUM_OBJ  = 6,
    parameter int NUM_PAD  = 6,
    parameter int ADDR_W   = 4,
    parameter int PAD_BASE = 8,
    localparam int NUM_PAIR = NUM_OBJ * (NUM_OBJ - 1) / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] obj_en,
    input  logic [NUM_PAD-1:0] pad_in,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_en,
    input  logic               clr_we,
    output logic [1:0]         rd_data,
    output logic               rd_oe
);
    logic [NUM_PAIR-1:0] flags_q;
    logic [NUM_PAD-1:0]  pads_s;

    coll_detect #(.NUM_OBJ(NUM_OBJ)) u_det (
        .clk(clk), .rst_n(rst_n), .obj_en(obj_en), .clr(clr_we), .flags(flags_q)
    );

    pad_sync #(.WIDTH(NUM_PAD)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pads_s)
    );

    status_read_mux #(
        .NUM_PAIR(NUM_PAIR), .NUM_PAD(NUM_PAD), .ADDR_W(ADDR_W), .PAD_BASE(PAD_BASE)
    ) u_mux (
        .flags(flags_q), .pads(pads_s), .rd_addr(rd_addr), .rd_en(rd_en),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );
endmodule

// File: rtl/coll_status_chk.sv
// Property checker for coll_status_port. It is attached to the top module
// by a bind statement and observes the ports and the flag register.
module coll_status_chk #(
    parameter int NUM_OBJ  = 6,
    parameter int ADDR_W   = 4,
    localparam int NUM_PAIR = NUM_OBJ * (NUM_OBJ - 1) / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_OBJ-1:0]  obj_en,
    input logic                clr_we,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [1:0]          rd_data,
    input logic                rd_oe,
    input logic [NUM_PAIR-1:0] flags
);
    // R2: set flags remain set when no clear is requested.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)));

    // R4: at most one object enabled, and no clear, leaves the flags unchanged.
    a_r4_single_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(obj_en) <= 1 && !clr_we) |=> $stable(flags));

    // R5: a clear with no objects enabled empties every flag.
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && obj_en == '0) |=> (flags == '0));

    // R6: a collision on objects 0 and 1 survives a clear in the same cycle.
    a_r6_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && obj_en[0] && obj_en[1]) |=> flags[0]);

    // R7: the spare bit of the last collision address reads 0.
    a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(7)) |-> (rd_data[0] == 1'b0));

    // R9: with the read strobe low there is no drive and the data is 0.
    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (!rd_oe && rd_data == 2'b00));
endmodule

bind coll_status_port coll_status_chk #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .obj_en(obj_en), .clr_we(clr_we), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe), .flags(flags_q)
);

// File: tb/sim_coll_status_port.sv
`timescale 1ns/1ps
module sim_coll_status_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] obj_en = '0;
    logic [5:0] pad_in = '0;
    logic [3:0] rd_addr = '0;
    logic       rd_en = 1'b0;
    logic       clr_we = 1'b0;
    logic [1:0] rd_data;
    logic       rd_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coll_status_port u0 (
        .clk(clk), .rst_n(rst_n), .obj_en(obj_en), .pad_in(pad_in),
        .rd_addr(rd_addr), .rd_en(rd_en), .clr_we(clr_we),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    // {object pattern, expected flag vector with bit 15 = 0}.
    // The pair numbering is that of R3.
    localparam logic [21:0] VEC [8] = '{
        {6'b000001, 16'h0000},   // R4: one object only
        {6'b000011, 16'h0001},   // pair (0,1), k=0, addr 0 bit 7
        {6'b100001, 16'h0010},   // pair (0,5), k=4, addr 2 bit 7
        {6'b010010, 16'h0080},   // pair (1,4), k=7, addr 3 bit 6
        {6'b001100, 16'h0200},   // pair (2,3), k=9, addr 4 bit 6
        {6'b110000, 16'h4000},   // pair (4,5), k=14, addr 7 bit 7
        {6'b000111, 16'h0023},   // three objects: k=0,1,5
        {6'b111111, 16'h7FFF}    // all pairs; R7 spare bit stays 0
    };

    task automatic chk(input string req, input logic [3:0] a, input logic en,
                       input logic [1:0] exp_d, input logic exp_oe);
        @(negedge clk);
        rd_addr = a;
        rd_en = en;
        #1;
        n_cmp++;
        if (rd_data !== exp_d || rd_oe !== exp_oe) begin
            n_bad++;
            $display("FAIL %s addr=%0d data=%b oe=%b expected data=%b oe=%b",
                     req, a, rd_data, rd_oe, exp_d, exp_oe);
        end
        rd_en = 1'b0;
    endtask

    task automatic chk_all(input string req, input logic [15:0] f);
        for (int a = 0; a < 8; a++)
            chk(req, 4'(a), 1'b1, {f[2*a], f[2*a+1]}, 1'b1);
    endtask

    task automatic clear_and_apply(input logic [5:0] pat);
        @(negedge clk); clr_we = 1'b1; obj_en = '0;
        @(negedge clk); clr_we = 1'b0; obj_en = pat;
        @(negedge clk); obj_en = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of the flags and of the controller bits.
        chk_all("R1", 16'h0000);
        chk("R1", 4'd8, 1'b1, 2'b00, 1'b1);

        // R2/R3/R4/R7: table of object patterns.
        for (int v = 0; v < 8; v++) begin
            clear_and_apply(VEC[v][21:16]);
            repeat (2) @(negedge clk);     // the flags must persist (R2)
            chk_all("R2_R3", VEC[v][15:0]);
        end

        // R10: reading again after the full sweep leaves all flags set.
        chk_all("R10", 16'h7FFF);
        chk("R7", 4'd7, 1'b1, 2'b10, 1'b1);

        // R6: a clear in the same cycle as a (0,1) collision keeps k=0.
        @(negedge clk); clr_we = 1'b1; obj_en = 6'b000011;
        @(negedge clk); clr_we = 1'b0; obj_en = '0;
        chk("R6", 4'd0, 1'b1, 2'b10, 1'b1);
        chk("R5", 4'd1, 1'b1, 2'b00, 1'b1);
        chk("R5", 4'd7, 1'b1, 2'b00, 1'b1);

        // R5: a plain clear empties everything.
        @(negedge clk); clr_we = 1'b1;
        @(negedge clk); clr_we = 1'b0;
        chk_all("R5", 16'h0000);

        // R8: a controller pin is visible two edges later, on bit 7.
        @(negedge clk); pad_in = 6'b101010;
        @(negedge clk);                      // one edge: not visible yet
        rd_addr = 4'd9; rd_en = 1'b1; #1;
        n_cmp++;
        if (rd_data !== 2'b00) begin
            n_bad++;
            $display("FAIL R8 early data=%b expected 00", rd_data);
        end
        rd_en = 1'b0;
        for (int p = 0; p < 6; p++)
            chk("R8", 4'(8 + p), 1'b1, {pad_in[p], 1'b0}, 1'b1);

        // R9: unmapped addresses and a low strobe give no drive.
        chk("R9", 4'd14, 1'b1, 2'b00, 1'b0);
        chk("R9", 4'd15, 1'b1, 2'b00, 1'b0);
        chk("R9", 4'd9, 1'b0, 2'b00, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule